// File: doc/BRIEF.md
# Address-Latched Static Memory with Shared Data Bus

This block models a 1024-word by 4-bit static memory. It is controlled by two active-low strobes: an enable and a write. All of its pins are sampled on a fast system clock. The strobe edges are detected from those samples, so the memory behaves like a strobe-driven asynchronous part while staying fully synchronous inside. The shared data bus is split into a data input, a data output and an output-enable flag. A pad ring or a bus-fabric model combines them into one three-state bus.

The enable falling edge starts a cycle and freezes the address in an internal register. A read presents the stored word a fixed number of clocks later. The word stays on the bus until enable returns high. A write happens while both strobes are low. The word is committed when the first of the two strobes returns high, using the data sampled on that clock. The data path is gated by the ordering of the strobes. If write falls after enable, the bus is briefly driven and then released. If write is already low when enable falls and stays low past the enable rise, the bus is never driven. Write may stay low across a run of enable cycles to fill several addresses in a row.

Top module: `latched_sram`

## Requirements
- R1: While rst_n is low, dout_oe is 0 and dout is 0.
- R2: The address is taken from the addr pins sampled on the clock at which en_n is first seen low. Any later change of addr in the same cycle does not alter which word is read or written.
- R3: dout_oe is 1 in the clock cycle after a rising clock edge that sampled en_n=0 and wr_n=1. In every other case it is 0.
- R4: After the edge that first samples en_n low, dout stays 0 for READ_LAT-1 cycles. dout carries the stored word from the READ_LAT-th following edge and keeps it unchanged while en_n stays low and wr_n stays high.
- R5: While en_n is high, nothing is driven. Activity on wr_n, din and addr while en_n is high changes no stored word.
- R6: If en_n falls while wr_n is high and wr_n falls later, dout_oe goes high and then drops while wr_n is low. The write commits when wr_n returns high, and dout_oe rises again while en_n is still low.
- R7: If wr_n is low before en_n falls and stays low until after en_n rises, dout_oe stays 0 for the whole cycle. The word is captured from din sampled with the en_n rise.
- R8: With wr_n held low over several consecutive enable cycles, each cycle writes its own captured address.
- R9: Address bits [9:4] select one of 64 rows and bits [3:0] select one of 16 four-bit groups within the row. All 1024 words are independent.
- R10: A write stores the din value sampled on the clock where the first strobe is seen high again. Values on din earlier in the same cycle are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low enable strobe; its fall starts a cycle |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 10 | Word address, captured at the enable fall |
| din | input | 4 | Write data from the shared bus |
| dout | output | 4 | Read data toward the shared bus |
| dout_oe | output | 1 | Bus drive enable for dout |

## Verification
The bench builds the block with the default 10-bit address, 4-bit word and 4-bit group select, and with READ_LAT raised to 3. This makes the zero-before-valid window two cycles long, so an off-by-one in the latency counter shows up at the ports. Both strobe orderings are driven, along with a write burst that holds the write strobe low and a full sweep of one row's 16 groups next to its neighbour rows. Ignored writes are also driven while the enable is high. Every stored word is written before it is read.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

  // Sampled copy of the two control strobes, both active low.
  typedef struct packed {
    logic en_n;
    logic wr_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{en_n: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/lsram_sampler.sv
module lsram_sampler
  import lsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output strobe_t           cur,
  output strobe_t           prv,
  output logic [ADDR_W-1:0] addr_s,
  output logic [DATA_W-1:0] din_s
);

  strobe_t cur_nxt;

  always_comb begin
    cur_nxt.en_n = en_n;
    cur_nxt.wr_n = wr_n;
  end

  // Every pin is registered once; the previous strobe sample gives edge history.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= STROBE_IDLE;
      prv    <= STROBE_IDLE;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      cur    <= cur_nxt;
      prv    <= cur;
      addr_s <= addr;
      din_s  <= din;
    end
  end

endmodule

// File: rtl/lsram_array.sv
module lsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int ROWS   = 1 << ROW_W;
  localparam int GROUPS = 1 << COL_W;
  localparam int LINE_W = GROUPS * DATA_W;

  logic [LINE_W-1:0] line_q [ROWS];

  logic [ROW_W-1:0] w_row, r_row;
  logic [COL_W-1:0] w_col, r_col;
  logic [LINE_W-1:0] r_line;
  logic [DATA_W-1:0] grp [GROUPS];

  assign w_row = wr_addr[ADDR_W-1:COL_W];
  assign w_col = wr_addr[COL_W-1:0];
  assign r_row = rd_addr[ADDR_W-1:COL_W];
  assign r_col = rd_addr[COL_W-1:0];

  // Row storage has no reset: contents are undefined until written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_q[w_row][w_col*DATA_W +: DATA_W] <= wr_data;
    end
  end

  assign r_line = line_q[r_row];

  // Split the selected row into its column groups, then pick one.
  for (genvar g = 0; g < GROUPS; g++) begin : g_col
    assign grp[g] = r_line[g*DATA_W +: DATA_W];
  end

  assign rd_data = grp[r_col];

endmodule

// File: rtl/lsram_ctrl.sv
module lsram_ctrl
  import lsram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           cur,
  input  strobe_t           prv,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout_oe,
  output logic [DATA_W-1:0] dout
);

  localparam int CNT_W = $clog2(READ_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C  = CNT_W'(READ_LAT);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(READ_LAT - 1);

  logic              fall;
  logic              commit;
  logic [ADDR_W-1:0] addr_lat_nxt;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [DATA_W-1:0] hold, hold_nxt;
  logic              hold_ld;

  // Enable seen high on the previous sample and low on this one.
  assign fall = prv.en_n & ~cur.en_n;

  // Both strobes were low, and now the first one of them has returned high.
  assign commit = ~prv.en_n & ~prv.wr_n & (cur.en_n | cur.wr_n);

  always_comb begin
    addr_lat_nxt = addr_lat;
    cnt_nxt      = cnt;
    hold_ld      = 1'b0;
    if (fall) begin
      addr_lat_nxt = addr_s;
      cnt_nxt      = CNT_W'(1);
    end else if (cur.en_n) begin
      cnt_nxt = '0;
    end else begin
      if (cnt != LAT_C) cnt_nxt = cnt + 1'b1;
      if (cnt == LOAD_C) hold_ld = 1'b1;
    end
    hold_nxt = hold_ld ? rd_data : hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat <= '0;
      cnt      <= '0;
      hold     <= '0;
    end else begin
      addr_lat <= addr_lat_nxt;
      cnt      <= cnt_nxt;
      hold     <= hold_nxt;
    end
  end

  assign wr_en   = commit;
  assign wr_data = din_s;
  assign dout_oe = ~cur.en_n & cur.wr_n;
  assign dout    = (dout_oe && cnt == LAT_C) ? hold : '0;

endmodule

// File: rtl/latched_sram.sv
module latched_sram
  import lsram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 4,
  parameter int COL_W    = 4,
  parameter int READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  strobe_t           cur_s, prv_s;
  logic [ADDR_W-1:0] addr_s, addr_lat;
  logic [DATA_W-1:0] din_s, rd_data, wr_data;
  logic              wr_en;

  lsram_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_samp (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (en_n),
    .wr_n  (wr_n),
    .addr  (addr),
    .din   (din),
    .cur   (cur_s),
    .prv   (prv_s),
    .addr_s(addr_s),
    .din_s (din_s)
  );

  lsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (cur_s),
    .prv     (prv_s),
    .addr_s  (addr_s),
    .din_s   (din_s),
    .rd_data (rd_data),
    .addr_lat(addr_lat),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .dout_oe (dout_oe),
    .dout    (dout)
  );

  lsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_array (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(addr_lat),
    .wr_data(wr_data),
    .rd_addr(addr_lat),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/lsram_chk.sv
module lsram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              wr_n,
  input logic              dout_oe,
  input logic [DATA_W-1:0] dout,
  input logic              s_en,
  input logic              s_en_d,
  input logic [ADDR_W-1:0] addr_lat
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!dout_oe && dout == '0));

  // R3
  oe_needs_read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> ($past(!en_n) && $past(wr_n)));

  // R5
  en_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_n) |-> !dout_oe);

  // R7
  wr_low_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_n) |-> !dout_oe);

  // R4
  dout_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != '0) |-> dout_oe);

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && $past(dout) != '0) |-> $stable(dout));

  // R2
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!s_en && !s_en_d) |-> $stable(addr_lat));

endmodule

bind latched_sram lsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_n    (en_n),
  .wr_n    (wr_n),
  .dout_oe (dout_oe),
  .dout    (dout),
  .s_en    (cur_s.en_n),
  .s_en_d  (prv_s.en_n),
  .addr_lat(addr_lat)
);

// File: tb/latched_sram_tb_top.sv
`timescale 1ns/1ps
module latched_sram_tb_top;

  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 4;
  localparam int COL_W    = 4;
  localparam int READ_LAT = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en_n, wr_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              dout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string             req;
    logic              exp_oe;
    logic              chk_dout;
    logic [DATA_W-1:0] exp_dout;
  } item_t;

  item_t exp_q[$];

  always #2.5 clk = ~clk;

  latched_sram #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .READ_LAT(READ_LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic tic();
    @(negedge clk);
  endtask

  task automatic expect_out(input string r, input logic oe, input logic chk,
                            input logic [DATA_W-1:0] d);
    item_t it;
    it.req = r; it.exp_oe = oe; it.chk_dout = chk; it.exp_dout = d;
    exp_q.push_back(it);
  endtask

  // Monitor: compares queued expectations 1 ns after each falling clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (dout_oe !== it.exp_oe) begin
          errors++;
          $display("FAIL %s: dout_oe actual=%b expected=%b", it.req, dout_oe, it.exp_oe);
        end else if (it.chk_dout && dout !== it.exp_dout) begin
          errors++;
          $display("FAIL %s: dout actual=%h expected=%h", it.req, dout, it.exp_dout);
        end
      end
    end
  end

  // Read cycle: checks the pre-latency zero, the valid word, the hold and the release.
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                    input string r);
    en_n = 1'b0; wr_n = 1'b1; addr = a;
    tic(); expect_out("R3 drive on read", 1'b1, 1'b1, '0);
    addr = ~a;                                  // R2: late address change ignored
    repeat (READ_LAT - 1) tic();
    expect_out("R4 before latency", 1'b1, 1'b1, '0);
    tic(); expect_out(r, 1'b1, 1'b1, exp);
    addr = a ^ 10'h001;
    tic(); expect_out("R4 hold", 1'b1, 1'b1, exp);
    en_n = 1'b1;
    tic(); expect_out("R5 release", 1'b0, 1'b1, '0);
  endtask

  // Write with write strobe low before enable falls and until after it rises.
  task automatic wr_late(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_n = 1'b0; din = ~d;
    tic(); en_n = 1'b0; addr = a;
    tic(); expect_out("R7 no drive", 1'b0, 1'b1, '0);
    addr = ~a; din = d;
    tic(); expect_out("R7 no drive", 1'b0, 1'b1, '0);
    en_n = 1'b1;
    tic(); expect_out("R7 no drive", 1'b0, 1'b1, '0);
    wr_n = 1'b1; din = ~d;
    tic();
  endtask

  // Write with enable falling first, then write strobe.
  task automatic wr_early(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] dmid,
                          input logic [DATA_W-1:0] d);
    en_n = 1'b0; wr_n = 1'b1; addr = a;
    tic(); expect_out("R6 drive before write", 1'b1, 1'b0, '0);
    wr_n = 1'b0; din = dmid; addr = ~a;
    tic(); expect_out("R6 release on write", 1'b0, 1'b1, '0);
    tic(); din = d;
    tic(); wr_n = 1'b1;
    tic(); expect_out("R6 drive after write", 1'b1, 1'b0, '0);
    din = dmid;
    tic(); en_n = 1'b1;
    tic(); expect_out("R6 end", 1'b0, 1'b1, '0);
  endtask

  // R8: wr_n held low while enable pulses once per group of one row.
  task automatic wr_burst_row(input logic [ADDR_W-COL_W-1:0] row);
    wr_n = 1'b0;
    for (int g = 0; g < (1 << COL_W); g++) begin
      en_n = 1'b0; addr = {row, COL_W'(g)}; din = '0;
      tic(); din = DATA_W'(g) ^ 4'h9; addr = '0;
      tic(); expect_out("R8 burst no drive", 1'b0, 1'b1, '0);
      en_n = 1'b1;
      tic();
    end
    wr_n = 1'b1;
    tic();
  endtask

  initial begin
    rst_n = 1'b1; en_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    #1 rst_n = 1'b0;
    repeat (3) tic();
    expect_out("R1 reset", 1'b0, 1'b1, '0);
    tic();
    rst_n = 1'b1;
    tic(); tic();

    wr_late(10'h000, 4'h5);
    wr_late(10'h3FF, 4'hA);
    rd(10'h000, 4'h5, "R2 read addr 000");
    rd(10'h3FF, 4'hA, "R7 read addr 3FF");

    // R9: one row swept by group, neighbours on both sides
    wr_late({6'd4, 4'd15}, 4'h1);
    wr_late({6'd6, 4'd0}, 4'hE);
    wr_burst_row(6'd5);
    for (int g = 0; g < 16; g++) begin
      rd({6'd5, 4'(g)}, 4'(g) ^ 4'h9, "R9 row group readback");
    end
    rd({6'd4, 4'd15}, 4'h1, "R9 lower neighbour");
    rd({6'd6, 4'd0}, 4'hE, "R9 upper neighbour");

    // R6 / R10: early-enable write, mid-cycle data discarded
    wr_early(10'h155, 4'h3, 4'hC);
    rd(10'h155, 4'hC, "R10 last data wins");

    // R5: strobe and data activity with enable high must not write
    wr_n = 1'b0; addr = 10'h000; din = 4'hF;
    tic(); expect_out("R5 idle no drive", 1'b0, 1'b1, '0);
    din = 4'h0; addr = 10'h155;
    tic(); wr_n = 1'b1;
    tic();
    rd(10'h000, 4'h5, "R5 addr 000 untouched");
    rd(10'h155, 4'hC, "R5 addr 155 untouched");

    wr_late(10'h3FF, 4'h0);
    rd(10'h3FF, 4'h0, "R7 overwrite to zero");

    tic(); tic();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule